// File: doc/BRIEF.md
# Programmable Frame Sync Delay Generator

This block conditions the frame sync strobes of a four-port serial telephony line interface. Every port watches its own incoming frame sync. When a rising edge appears, the port waits a programmed number of data clock cycles. It then emits a clean output pulse whose length comes from a two-bit width code. The widths are not a linear count: the codes select 1, 2, 8 or 16 cycles. A delay of zero bypasses the port. The incoming strobe then goes straight to the output, and the width code has no effect.

Each port has one 16-bit configuration word on a small register bus. A write uses a port select, a write strobe and a write data bus, and a read returns the selected word on a separate read data bus. The counter only counts clock cycles. In a line mode that spends two clocks on every data bit, software has to program twice the delay it wants. Hardware reset clears every configuration word, and so does a synchronous software clear input. Only short frame sync is produced; the width code never selects a long-sync mode.

Top module: `fsd_delay_unit`

## Requirements
- R1: Each of the four ports has its own 16-bit configuration word. A write with `reg_wr` high at a clock edge stores `reg_wdata` into the word picked by `reg_sel`, and `reg_rdata` shows the selected word combinationally.
- R2: Bits [9:0] of a configuration word hold the delay (0 to 1023), bits [15:14] hold the width code, and bits [13:10] are reserved. Reserved bits are discarded on write and read back as zero, so writing 0xFFFF reads back 0xC3FF.
- R3: After a hardware reset, and one cycle after `sw_clear` is sampled high, every configuration word reads zero and every port is in bypass.
- R4: With a nonzero delay D, an input rising edge first sampled at clock edge k raises `fs_out` right after clock edge k+D.
- R5: The output pulse lasts exactly 1, 2, 8 or 16 clock cycles for width codes 00, 01, 10 and 11 respectively.
- R6: With a delay of zero, `fs_out` follows `fs_in` combinationally for that port, for the full time the input is high, whatever the width code.
- R7: A new input rising edge during a running countdown restarts the count from the new edge. The earlier pending pulse is dropped.
- R8: Only rising edges start a countdown. An input held high for many cycles gives a single pulse, and a falling edge gives none.
- R9: The largest delay, 1023, produces a pulse 1023 cycles after the captured edge.
- R10: The ports are independent. Simultaneous edges on all ports with different settings each produce their own correctly timed pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock shared by all ports and the register bus |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sw_clear | input | 1 | Synchronous clear of all configuration words |
| fs_in | input | NUM_PORTS (4) | Incoming frame sync strobe, one bit per port |
| fs_out | output | NUM_PORTS (4) | Delayed and stretched frame sync, one bit per port |
| reg_sel | input | clog2(NUM_PORTS) (2) | Port select for register reads and writes |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | REG_W (16) | Write data |
| reg_rdata | output | REG_W (16) | Read data of the selected port |

## Verification
The bench builds the block with its defaults: four ports, a 10-bit delay field in a 16-bit word, and no input synchronizer stages. This makes every edge-to-pulse latency an exact cycle count that the scoreboard predicts. The full 10-bit field brings the 1023-cycle maximum delay within reach. The power-of-two port count uses the direct read-select variant. All four width codes and the zero-delay bypass can also be reached on one port, so each timing path is checked at the output pins.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

   localparam int unsigned FSD_CODE_W    = 2;
   localparam int unsigned FSD_MAX_PULSE = 16;
   localparam int unsigned FSD_PCNT_W    = $clog2(FSD_MAX_PULSE);

   typedef logic [FSD_CODE_W-1:0] fsd_code_t;
   typedef logic [FSD_PCNT_W-1:0] fsd_pcnt_t;

   typedef enum logic [FSD_CODE_W-1:0] {
      PW_ONE     = 2'b00,
      PW_TWO     = 2'b01,
      PW_EIGHT   = 2'b10,
      PW_SIXTEEN = 2'b11
   } fsd_pw_e;

   // Remaining high cycles after the first one: width minus one.
   function automatic fsd_pcnt_t fsd_pulse_extra(fsd_code_t code);
      fsd_pcnt_t r;
      case (fsd_pw_e'(code))
         PW_ONE:     r = fsd_pcnt_t'(0);
         PW_TWO:     r = fsd_pcnt_t'(1);
         PW_EIGHT:   r = fsd_pcnt_t'(7);
         default:    r = fsd_pcnt_t'(FSD_MAX_PULSE - 1);
      endcase
      return r;
   endfunction

endpackage

// File: rtl/fsd_cfg_bank.sv
module fsd_cfg_bank
   import fsd_pkg::*;
#(
   parameter int unsigned NUM_PORTS = 4,
   parameter int unsigned REG_W     = 16,
   parameter int unsigned DELAY_W   = 10,
   parameter int unsigned SEL_W     = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            sw_clear,
   input  logic [SEL_W-1:0]                sel,
   input  logic                            wr,
   input  logic [REG_W-1:0]                wdata,
   output logic [REG_W-1:0]                rdata,
   output logic [NUM_PORTS*DELAY_W-1:0]    delay_o,
   output logic [NUM_PORTS*FSD_CODE_W-1:0] code_o
);

   localparam int unsigned CODE_LSB = REG_W - FSD_CODE_W;
   localparam logic [REG_W-1:0] DLY_MASK  = REG_W'((1 << DELAY_W) - 1);
   localparam logic [REG_W-1:0] CODE_MASK = REG_W'((1 << FSD_CODE_W) - 1) << CODE_LSB;
   localparam logic [REG_W-1:0] KEEP_MASK = DLY_MASK | CODE_MASK;

   initial begin
      assert_fields_fit_R2: assert (DELAY_W + FSD_CODE_W <= REG_W)
         else $error("delay and width fields overlap in a %0d-bit word", REG_W);
      assert_sel_width_R1: assert ((1 << SEL_W) >= NUM_PORTS)
         else $error("port select too narrow");
   end

   logic [REG_W-1:0] cfg_q [NUM_PORTS];

   for (genvar g = 0; g < NUM_PORTS; g++) begin : g_word
      logic hit;
      assign hit = wr && (sel == SEL_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_q[g] <= '0;
         end else if (sw_clear) begin
            cfg_q[g] <= '0;
         end else if (hit) begin
            cfg_q[g] <= wdata & KEEP_MASK;
         end
      end

      assign delay_o[g*DELAY_W +: DELAY_W]       = cfg_q[g][DELAY_W-1:0];
      assign code_o[g*FSD_CODE_W +: FSD_CODE_W]  = cfg_q[g][REG_W-1 -: FSD_CODE_W];

      assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
         sw_clear |=> (cfg_q[g] == '0));
   end

   if (NUM_PORTS == (1 << SEL_W)) begin : g_rd_full
      assign rdata = cfg_q[sel];
   end else begin : g_rd_guard
      always_comb begin
         rdata = '0;
         for (int i = 0; i < NUM_PORTS; i++) begin
            if (sel == SEL_W'(i)) rdata = cfg_q[i];
         end
      end
   end

   assert_write_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !sw_clear && (int'(sel) < NUM_PORTS))
      |=> (cfg_q[$past(sel)] == ($past(wdata) & KEEP_MASK)));

   assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata & ~KEEP_MASK) == '0);

endmodule

// File: rtl/fsd_lane.sv
module fsd_lane
   import fsd_pkg::*;
#(
   parameter int unsigned DELAY_W     = 10,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DELAY_W-1:0] delay_i,
   input  fsd_code_t          code_i,
   input  logic               fs_i,
   output logic               fs_o
);

   logic fs_s;

   if (SYNC_STAGES == 0) begin : g_direct
      assign fs_s = fs_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sr_q <= '0;
         end else begin
            sr_q[0] <= fs_i;
            for (int i = 1; i < SYNC_STAGES; i++) sr_q[i] <= sr_q[i-1];
         end
      end
      assign fs_s = sr_q[SYNC_STAGES-1];
   end

   logic               fs_q;
   logic [DELAY_W-1:0] cnt_q;
   logic               pulse_q;
   fsd_pcnt_t          pcnt_q;

   logic bypass, rise, expire;

   assign bypass = (delay_i == '0);
   assign rise   = fs_s & ~fs_q;
   assign expire = (cnt_q == DELAY_W'(1)) & ~rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_q <= 1'b0;
      end else begin
         fs_q <= fs_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (bypass) begin
         cnt_q <= '0;
      end else if (rise) begin
         cnt_q <= delay_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - DELAY_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_q <= 1'b0;
         pcnt_q  <= '0;
      end else if (bypass) begin
         pulse_q <= 1'b0;
         pcnt_q  <= '0;
      end else if (expire) begin
         pulse_q <= 1'b1;
         pcnt_q  <= fsd_pulse_extra(code_i);
      end else if (pulse_q) begin
         if (pcnt_q == '0) pulse_q <= 1'b0;
         else              pcnt_q  <= pcnt_q - 1'b1;
      end
   end

   assign fs_o = bypass ? fs_i : pulse_q;

   assert_reload_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !bypass) |=> (cnt_q == $past(delay_i)));

   assert_fire_on_expiry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_q) |-> ($past(cnt_q) == DELAY_W'(1)));

   assert_width_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pulse_q) && !$past(bypass)) |-> ($past(pcnt_q) == '0));

endmodule

// File: rtl/fsd_delay_unit.sv
module fsd_delay_unit
   import fsd_pkg::*;
#(
   parameter int unsigned NUM_PORTS   = 4,
   parameter int unsigned REG_W       = 16,
   parameter int unsigned DELAY_W     = 10,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         sw_clear,
   input  logic [NUM_PORTS-1:0]         fs_in,
   output logic [NUM_PORTS-1:0]         fs_out,
   input  logic [$clog2(NUM_PORTS)-1:0] reg_sel,
   input  logic                         reg_wr,
   input  logic [REG_W-1:0]             reg_wdata,
   output logic [REG_W-1:0]             reg_rdata
);

   localparam int unsigned SEL_W = $clog2(NUM_PORTS);

   initial begin
      assert_port_count_R1: assert (NUM_PORTS >= 2)
         else $error("at least two ports are needed");
      assert_delay_width_R9: assert (DELAY_W >= 1 && DELAY_W <= 16)
         else $error("delay field width out of range");
   end

   logic [NUM_PORTS*DELAY_W-1:0]    delay_all;
   logic [NUM_PORTS*FSD_CODE_W-1:0] code_all;

   fsd_cfg_bank #(
      .NUM_PORTS (NUM_PORTS),
      .REG_W     (REG_W),
      .DELAY_W   (DELAY_W),
      .SEL_W     (SEL_W)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_clear (sw_clear),
      .sel      (reg_sel),
      .wr       (reg_wr),
      .wdata    (reg_wdata),
      .rdata    (reg_rdata),
      .delay_o  (delay_all),
      .code_o   (code_all)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lane
      fsd_lane #(
         .DELAY_W     (DELAY_W),
         .SYNC_STAGES (SYNC_STAGES)
      ) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .delay_i (delay_all[p*DELAY_W +: DELAY_W]),
         .code_i  (code_all[p*FSD_CODE_W +: FSD_CODE_W]),
         .fs_i    (fs_in[p]),
         .fs_o    (fs_out[p])
      );
   end

endmodule

// File: tb/fsd_delay_unit_tb.sv
`timescale 1ns/100ps
module fsd_delay_unit_tb;

   localparam int NP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sw_clear = 1'b0;
   logic [NP-1:0] fs_in = '0;
   logic [NP-1:0] fs_out;
   logic [1:0]    reg_sel = '0;
   logic          reg_wr = 1'b0;
   logic [15:0]   reg_wdata = '0;
   logic [15:0]   reg_rdata;

   fsd_delay_unit u_dut (
      .clk(clk), .rst_n(rst_n), .sw_clear(sw_clear),
      .fs_in(fs_in), .fs_out(fs_out),
      .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   always #2.5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int failures = 0;
   logic [15:0] cfg_m [NP];
   int    exp_start [NP][$];
   int    exp_w     [NP][$];
   string exp_req   [NP][$];

   function automatic int wdec(logic [1:0] c);
      case (c)
         2'b00:   return 1;
         2'b01:   return 2;
         2'b10:   return 8;
         default: return 16;
      endcase
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic wr(int s, logic [15:0] d);
      @(negedge clk);
      reg_sel = 2'(s); reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      cfg_m[s] = d & 16'hC3FF;
   endtask

   task automatic rd_check(int s, logic [15:0] expv, string req);
      reg_sel = 2'(s);
      #0.5;
      chk(reg_rdata == expv, req, $sformatf("readback port %0d", s), int'(reg_rdata), int'(expv));
   endtask

   task automatic fire(logic [NP-1:0] mask, int hold, bit push, string req);
      int c;
      @(negedge clk);
      c = cyc;
      fs_in = fs_in | mask;
      for (int p = 0; p < NP; p++) begin
         if (mask[p] && push) begin
            int d;
            d = int'(cfg_m[p][9:0]);
            if (d == 0) begin
               exp_start[p].push_back(c);
               exp_w[p].push_back(hold);
            end else begin
               exp_start[p].push_back(c + 1 + d);
               exp_w[p].push_back(wdec(cfg_m[p][15:14]));
            end
            exp_req[p].push_back(req);
         end
      end
      repeat (hold) @(negedge clk);
      fs_in = fs_in & ~mask;
   endtask

   // Monitor: measures each output pulse and compares with the queue head.
   logic prev [NP];
   int   st [NP];
   int   ln [NP];
   initial for (int p = 0; p < NP; p++) begin prev[p] = 1'b0; st[p] = 0; ln[p] = 0; end

   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         for (int p = 0; p < NP; p++) begin
            if (fs_out[p]) begin
               if (!prev[p]) begin st[p] = cyc; ln[p] = 1; end
               else ln[p] = ln[p] + 1;
            end else if (prev[p]) begin
               if (exp_start[p].size() == 0) begin
                  chk(1'b0, "R8", $sformatf("unexpected pulse port %0d start", p), st[p], -1);
               end else begin
                  int es, ew;
                  string rq;
                  es = exp_start[p].pop_front();
                  ew = exp_w[p].pop_front();
                  rq = exp_req[p].pop_front();
                  chk(st[p] == es, rq, $sformatf("pulse start port %0d", p), st[p], es);
                  chk(ln[p] == ew, rq, $sformatf("pulse width port %0d", p), ln[p], ew);
               end
            end
            prev[p] = fs_out[p];
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; failures++;
      $display("FAIL R4 watchdog: actual=%0d cycles expected=completion", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int p = 0; p < NP; p++) cfg_m[p] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R3: reset state
      for (int p = 0; p < NP; p++) rd_check(p, 16'h0000, "R3");
      chk(fs_out == '0, "R3", "fs_out after reset", int'(fs_out), 0);

      // R1: per-port words, write then read back
      wr(0, 16'h4005);
      wr(1, 16'h800C);
      wr(2, 16'h0003);
      wr(3, 16'hC007);
      rd_check(0, 16'h4005, "R1");
      rd_check(1, 16'h800C, "R1");
      rd_check(2, 16'h0003, "R1");
      rd_check(3, 16'hC007, "R1");

      // R10 and R4: all ports at once, different settings
      fire(4'hF, 1, 1'b1, "R10");
      repeat (40) @(negedge clk);

      // R5: every width code on port 2 with delay 4
      for (int code = 0; code < 4; code++) begin
         wr(2, 16'((code << 14) | 4));
         fire(4'h4, 1, 1'b1, "R5");
         repeat (30) @(negedge clk);
      end

      // R8: long input level gives one pulse only
      fire(4'h1, 25, 1'b1, "R8");
      repeat (30) @(negedge clk);

      // R7: second edge restarts the count, first pulse dropped
      fire(4'h2, 1, 1'b0, "R7");
      repeat (4) @(negedge clk);
      fire(4'h2, 1, 1'b1, "R7");
      repeat (30) @(negedge clk);

      // R6: zero delay is transparent, width code ignored
      wr(0, 16'hC000);
      rd_check(0, 16'hC000, "R6");
      @(negedge clk);
      fs_in[0] = 1'b1;
      exp_start[0].push_back(cyc); exp_w[0].push_back(1); exp_req[0].push_back("R6");
      #0.5;
      chk(fs_out[0] == 1'b1, "R6", "bypass high", int'(fs_out[0]), 1);
      @(negedge clk);
      fs_in[0] = 1'b0;
      #0.5;
      chk(fs_out[0] == 1'b0, "R6", "bypass low", int'(fs_out[0]), 0);
      repeat (3) @(negedge clk);
      fire(4'h1, 3, 1'b1, "R6");
      repeat (20) @(negedge clk);

      // R2 and R9: reserved bits dropped, maximum delay
      wr(3, 16'hFFFF);
      rd_check(3, 16'hC3FF, "R2");
      fire(4'h8, 1, 1'b1, "R9");
      repeat (1050) @(negedge clk);

      // R3: software clear returns every port to bypass
      @(negedge clk);
      sw_clear = 1'b1;
      @(negedge clk);
      sw_clear = 1'b0;
      for (int p = 0; p < NP; p++) cfg_m[p] = '0;
      for (int p = 0; p < NP; p++) rd_check(p, 16'h0000, "R3");
      fire(4'hF, 2, 1'b1, "R3");
      repeat (10) @(negedge clk);

      for (int p = 0; p < NP; p++)
         chk(exp_start[p].size() == 0, "R8", $sformatf("missing pulses port %0d", p),
             exp_start[p].size(), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule